// File: doc/BRIEF.md
# Dual-Identity I2C Register Target

This block is an I2C target that answers to two fixed 7-bit device identifiers. One identifier opens a 128-byte control/status register space and the other opens a 128-byte general-purpose user space. Neither space is stored inside the block. Both are reached through a simple internal port: a space select, a word address, a write strobe with write data, and a read-data return. The storage sits beside the block and answers reads combinationally.

The target watches SCL and SDA, which are already synchronous to its system clock. It recognises START and STOP and shifts in the slave address byte. It pulls SDA low for the acknowledge only when the identifier matches. A write carries one word-address byte, which loads a shared address counter, followed by any number of data bytes. A read with no word address starts from the counter's current value. A random read is a write of the word address, then a repeated START, then a read. The target honours it only when the read phase names the same identifier as the write phase.

Top module: `dual_id_i2c_target`

## Requirements
- R1: The first byte after any START is the slave byte. Bits 7..1 are the identifier and bit 0 selects the direction: 1 is a read and 0 is a write. Data bytes travel MSB first.
- R2: Identifier 1101111b selects the register space (`mem_space_o` = 0). Identifier 1010111b selects the user space (`mem_space_o` = 1). Any other identifier is not acknowledged. After such an identifier, SDA stays released and every later byte is ignored (no acknowledge, no write) until the next START.
- R3: In a write, the byte after the slave byte is the word address. Its low 7 bits load the address counter, and the byte is acknowledged.
- R4: Each further byte of a write is acknowledged and written, with one `mem_wr_o` pulse, at the counter's address in the selected space. The counter then advances by one and wraps from 7Fh to 00h.
- R5: After reset the counter is 00h and SDA is released, so a read issued with no prior addressing returns the byte at 00h.
- R6: In a read, the target drives the byte at the counter's address onto SDA, MSB first, then advances the counter. It sends the next byte whenever the master acknowledges.
- R7: After the master answers a read byte with a NACK, the target releases SDA and waits for STOP or START.
- R8: A random read whose read phase repeats the write phase's identifier is acknowledged and returns data from the word address just set.
- R9: A random read whose read-phase identifier differs from the identifier in its dummy-write phase is not acknowledged, and the counter is not moved.
- R10: A STOP releases SDA and ends any pending random read. After a STOP, a read with either valid identifier is acknowledged.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_space_o | output | 1 | Selected space: 0 register, 1 user |
| mem_addr_o | output | ADDR_W | Current word address (the address counter) |
| mem_wr_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte stored at `mem_addr_o` in the selected space |

## Verification
The bench targets the wrap of the counter from 7Fh to 00h during a multi-byte write and a following random read. A design that saturated there, or carried the increment into a wider field, would write and read the wrong location. It sends a foreign identifier followed by a byte equal to a valid slave byte. A target that re-armed on any byte instead of waiting for START would acknowledge that byte, or write into the storage. It runs a random read whose two phases name different identifiers, then a plain read after STOP. A design that skipped the comparison would return data in the first case, and one that kept the stale identifier past STOP would refuse the second. Every SDA drive change is checked against SCL low, because a target that moved SDA with SCL high would create false START or STOP conditions.

// File: rtl/dit_pkg.sv
package dit_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_W   = 7;
    localparam int CNT_W  = 4;

    localparam logic [ID_W-1:0] ID_REGS = 7'b1101111;
    localparam logic [ID_W-1:0] ID_USER = 7'b1010111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WORD,
        ST_ACK_WORD,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_SEND,
        ST_MACK,
        ST_IGNORE
    } dit_state_e;

    typedef enum logic {
        SPACE_REGS = 1'b0,
        SPACE_USER = 1'b1
    } dit_space_e;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            rd;
    } dit_slave_byte_t;

    function automatic logic id_known(logic [ID_W-1:0] id);
        return (id == ID_REGS) || (id == ID_USER);
    endfunction

    function automatic dit_space_e id_space(logic [ID_W-1:0] id);
        return (id == ID_USER) ? SPACE_USER : SPACE_REGS;
    endfunction

endpackage

// File: rtl/dit_line_monitor.sv
module dit_line_monitor (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    // a data edge while the clock stays high is a bus condition
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/dit_addr_counter.sv
module dit_addr_counter #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (inc)
            ptr <= ptr + 1'b1;   // natural wrap at the top of the space
    end

    // R5
    counter_reset_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> ptr == '0);

endmodule

// File: rtl/dual_id_i2c_target.sv
module dual_id_i2c_target
    import dit_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              mem_space_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    logic scl_rise, scl_fall, start_det, stop_det;

    dit_state_e        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              oe;
    logic              wr;
    logic              is_rd;
    logic              mack;
    dit_space_e        space;
    logic              pend_vld;
    logic [ID_W-1:0]   pend_id;
    dit_slave_byte_t   sb;
    logic              byte_done;
    logic              send_load;
    logic              ctr_load;
    logic [ADDR_W-1:0] ptr;

    dit_line_monitor u_mon (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    assign sb        = rx_sr;
    assign byte_done = scl_fall && (bitcnt == FULL);
    assign send_load = !start_det && !stop_det && scl_fall &&
                       ((state == ST_ACK_ADDR && is_rd) || (state == ST_MACK && !mack));
    assign ctr_load  = !start_det && !stop_det && state == ST_WORD && byte_done;

    dit_addr_counter #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (ctr_load),
        .load_val(rx_sr[ADDR_W-1:0]),
        .inc     (wr | send_load),
        .ptr     (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            oe       <= 1'b0;
            wr       <= 1'b0;
            is_rd    <= 1'b0;
            mack     <= 1'b1;
            space    <= SPACE_REGS;
            pend_vld <= 1'b0;
            pend_id  <= '0;
        end else begin
            wr <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                oe     <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                oe       <= 1'b0;
                pend_vld <= 1'b0;
            end else begin
                if ((state == ST_ADDR || state == ST_WORD || state == ST_WDATA) && scl_rise) begin
                    rx_sr  <= {rx_sr[BYTE_W-2:0], sda_i};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (send_load) begin
                    tx_sr  <= mem_rdata_i;
                    oe     <= ~mem_rdata_i[BYTE_W-1];
                    bitcnt <= '0;
                    state  <= ST_SEND;
                end else begin
                    unique case (state)
                        ST_ADDR: if (byte_done) begin
                            bitcnt <= '0;
                            if (id_known(sb.id) && !(sb.rd && pend_vld && sb.id != pend_id)) begin
                                oe       <= 1'b1;
                                is_rd    <= sb.rd;
                                space    <= id_space(sb.id);
                                pend_vld <= !sb.rd;
                                pend_id  <= sb.id;
                                state    <= ST_ACK_ADDR;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_ACK_ADDR: if (scl_fall) begin
                            oe    <= 1'b0;
                            state <= ST_WORD;
                        end
                        ST_WORD: if (byte_done) begin
                            bitcnt <= '0;
                            oe     <= 1'b1;
                            state  <= ST_ACK_WORD;
                        end
                        ST_WDATA: if (byte_done) begin
                            bitcnt <= '0;
                            oe     <= 1'b1;
                            wr     <= 1'b1;
                            state  <= ST_ACK_WDATA;
                        end
                        ST_ACK_WORD, ST_ACK_WDATA: if (scl_fall) begin
                            oe    <= 1'b0;
                            state <= ST_WDATA;
                        end
                        ST_SEND: if (scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                oe    <= 1'b0;
                                state <= ST_MACK;
                            end else begin
                                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                                oe     <= ~tx_sr[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                        ST_MACK: begin
                            if (scl_rise)
                                mack <= sda_i;
                            else if (scl_fall)
                                state <= ST_IGNORE;   // master declined: stay off the line
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_oe_o    = oe;
    assign mem_space_o = space;
    assign mem_addr_o  = ptr;
    assign mem_wr_o    = wr;
    assign mem_wdata_o = rx_sr;

    // R4
    wr_advances_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |=> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe_o);

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i);

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe_o && !mem_wr_o);

endmodule

// File: tb/dual_id_i2c_target_bench.sv
module dual_id_i2c_target_bench;

    localparam int AW = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic mem_space;
    logic [AW-1:0] mem_addr;
    logic mem_wr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    wire  sda_line = sda_m & ~sda_oe;

    dual_id_i2c_target #(.ADDR_W(AW)) u_dual_id_i2c_target (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .mem_space_o(mem_space),
        .mem_addr_o (mem_addr),
        .mem_wr_o   (mem_wr),
        .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata)
    );

    function automatic logic [7:0] reg_init(int i);
        return 8'(i * 7 + 8'h31);
    endfunction
    function automatic logic [7:0] usr_init(int i);
        return 8'(8'hC0 ^ (i * 3));
    endfunction

    // storage served on the block's memory port
    logic [7:0] st_reg [128];
    logic [7:0] st_usr [128];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) begin
                st_reg[i] <= reg_init(i);
                st_usr[i] <= usr_init(i);
            end
        end else if (mem_wr) begin
            if (mem_space) st_usr[mem_addr] <= mem_wdata;
            else           st_reg[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = mem_space ? st_usr[mem_addr] : st_reg[mem_addr];

    // behavioural reference
    int checks = 0;
    int failures = 0;
    bit done = 0;
    int mdl_ptr = 0;
    logic [7:0] mdl_reg [128];
    logic [7:0] mdl_usr [128];
    logic [15:0] exp_wr [$];

    initial begin
        for (int i = 0; i < 128; i++) begin
            mdl_reg[i] = reg_init(i);
            mdl_usr[i] = usr_init(i);
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every clock: write strobes against the expected queue, drive changes against SCL
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_wr) begin
                if (exp_wr.size() == 0) begin
                    check("R2/R4 unexpected write", {mem_space, mem_addr, mem_wdata}, 16'hFFFF);
                end else begin
                    logic [15:0] e;
                    e = exp_wr.pop_front();
                    check("R4 write space/addr/data", {mem_space, mem_addr, mem_wdata}, e);
                end
            end
            if (sda_oe != oe_prev) check("R11 drive change with SCL low", scl_m, 0);
        end
        oe_prev <= sda_oe;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(2);
        scl_m = 1'b1; tick(3);
        sda_m = 1'b0; tick(3);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; tick(2);
        scl_m = 1'b1; tick(3);
        sda_m = 1'b1; tick(4);
    endtask

    task automatic put_bit(logic b);
        sda_m = b;    tick(2);
        scl_m = 1'b1; tick(4);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(2);
        scl_m = 1'b1; tick(2);
        b = sda_line; tick(2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic send_byte(logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(bit master_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(master_ack ? 1'b0 : 1'b1);
    endtask

    task automatic model_write(bit usr, logic [7:0] d);
        exp_wr.push_back({usr, 7'(mdl_ptr), d});
        if (usr) mdl_usr[mdl_ptr] = d;
        else     mdl_reg[mdl_ptr] = d;
        mdl_ptr = (mdl_ptr + 1) % 128;
    endtask

    function automatic logic [7:0] model_read(bit usr);
        logic [7:0] v;
        v = usr ? mdl_usr[mdl_ptr] : mdl_reg[mdl_ptr];
        mdl_ptr = (mdl_ptr + 1) % 128;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;

        tick(4);
        rst = 1'b0;
        tick(2);
        check("R5 reset SDA released", sda_oe, 0);
        check("R5 reset counter", mem_addr, 0);
        check("R5 reset no write", mem_wr, 0);

        // R5/R6: read without addressing starts at 00h, two bytes
        do_start();
        send_byte(8'hDF, ack);
        check("R1/R2 register read id acked", ack, 1);
        recv_byte(1, d);
        check("R5 first read at 00h", d, model_read(0));
        recv_byte(0, d);
        check("R6 sequential read", d, model_read(0));
        tick(2);
        check("R7 released after NACK", sda_oe, 0);
        do_stop();
        check("R6 counter after read", mem_addr, mdl_ptr);

        // R3/R4: write across the top of the space
        do_start();
        send_byte(8'hDE, ack);
        check("R1 register write id acked", ack, 1);
        send_byte(8'h7E, ack);
        mdl_ptr = 8'h7E;
        check("R3 word address acked", ack, 1);
        model_write(0, 8'h11); send_byte(8'h11, ack); check("R4 data acked", ack, 1);
        model_write(0, 8'h22); send_byte(8'h22, ack); check("R4 data acked", ack, 1);
        model_write(0, 8'h33); send_byte(8'h33, ack); check("R4 data acked after wrap", ack, 1);
        do_stop();
        check("R4 counter wrapped", mem_addr, mdl_ptr);

        // R8: random read across the wrap
        do_start();
        send_byte(8'hDE, ack);
        send_byte(8'h7F, ack);
        mdl_ptr = 8'h7F;
        do_start();
        send_byte(8'hDF, ack);
        check("R8 matching read phase acked", ack, 1);
        recv_byte(1, d);
        check("R8 random read data", d, model_read(0));
        recv_byte(0, d);
        check("R8 read wraps to 00h", d, model_read(0));
        do_stop();

        // R2: user space is separate
        do_start();
        send_byte(8'hAE, ack);
        check("R2 user write id acked", ack, 1);
        send_byte(8'h20, ack);
        mdl_ptr = 8'h20;
        model_write(1, 8'hC4);
        send_byte(8'hC4, ack);
        do_stop();
        do_start();
        send_byte(8'hAE, ack); send_byte(8'h20, ack); mdl_ptr = 8'h20;
        do_start();
        send_byte(8'hAF, ack);
        recv_byte(0, d);
        check("R2 user space read back", d, model_read(1));
        do_stop();
        do_start();
        send_byte(8'hDE, ack); send_byte(8'h20, ack); mdl_ptr = 8'h20;
        do_start();
        send_byte(8'hDF, ack);
        recv_byte(0, d);
        check("R2 register space untouched", d, model_read(0));
        do_stop();

        // R2: foreign identifier, then bytes that must all be ignored
        do_start();
        send_byte(8'hA0, ack);
        check("R2 foreign id not acked", ack, 0);
        send_byte(8'hDE, ack);
        check("R2 valid-looking byte ignored", ack, 0);
        send_byte(8'h55, ack);
        check("R2 data ignored", ack, 0);
        check("R2 SDA released", sda_oe, 0);
        do_stop();
        check("R2 counter unchanged", mem_addr, mdl_ptr);

        // R9: read phase names the other identifier
        do_start();
        send_byte(8'hDE, ack);
        send_byte(8'h10, ack);
        mdl_ptr = 8'h10;
        do_start();
        send_byte(8'hAF, ack);
        check("R9 mismatched read phase not acked", ack, 0);
        check("R9 SDA released", sda_oe, 0);
        do_stop();
        check("R9 counter not moved", mem_addr, mdl_ptr);

        // R10: after STOP any valid identifier reads from the counter
        do_start();
        send_byte(8'hAF, ack);
        check("R10 read after STOP acked", ack, 1);
        recv_byte(0, d);
        check("R10 current-address user read", d, model_read(1));
        do_stop();
        check("R10 SDA released after STOP", sda_oe, 0);

        tick(10);
        check("R4 all expected writes seen", exp_wr.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule